// File: doc/BRIEF.md
# BCH Error Location Applier

This block finishes the correction of one data sector after a BCH decoder has located the bad bits. Once started, it waits for the decoder to signal that its result is ready. On that cycle it takes in one flag word and a set of packed position words. If the flags say that errors were found and none of them is uncorrectable, it visits each reported bit position in turn. For each position it reads the affected byte from a sector buffer and writes it back with that one bit inverted.

Positions that point past the data area land in the parity bytes, so the block skips them. It reports the outcome with a single-cycle completion pulse and one of four result flags: clean, corrected, uncorrectable or timed out. The result flag stays set until the next start. Syndrome computation and root search happen upstream and are not part of this block.

Top module: `bch_fix_apply`

## Requirements
- R1: After reset, `done`, all four result flags, `bufRdEn` and `bufWrEn` are low.
- R2: After `start`, the block makes no buffer access and raises no `done` until `decReady` is seen high. The flag word and position words are captured on the cycle `decReady` is sampled, so later changes on those inputs have no effect on the sector.
- R3: If `decReady` has not been seen within TIMEOUT_CYCLES clock edges after the start edge, the block finishes with `isTimeout` set and makes no buffer access.
- R4: If bit 1 of the flag word (errors found) is 0, the block finishes with `isClean` one edge after the ready edge and makes no buffer access. This holds whatever the other flag bits are.
- R5: If bit 1 is 1 and bit 0 (too many errors) is 1, the block finishes with `isUncorr` one edge after the ready edge and makes no buffer access.
- R6: The number of positions to apply is taken from flag word bits [7:4] and clamped to MAX_ERR (8). A count of 0 with bit 1 set finishes as corrected with no buffer access.
- R7: Position word k (k = 0..3) carries position 2k+1 in bits [12:0] and position 2k+2 in bits [28:16]. Positions are applied strictly in that order.
- R8: A position p below the limit is applied as follows. First a read cycle at byte address p/8. On the next cycle a write to the same address of the read byte XOR (1 << (p mod 8)). The buffer returns read data one cycle after `bufRdEn`.
- R9: A position of 8*SECTOR_BYTES (4096) or more costs one cycle and causes no buffer access.
- R10: `done` is high for exactly one cycle. Exactly one result flag is set at `done`, and that flag stays set until the next `start`.
- R11: Two positions in the same byte are both applied, because each write completes before the next read.
- R12: The time from the ready edge to `done` is 2 + 3n + m edges for a corrected sector, where n is the number of positions applied and m the number skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing one sector (sampled while idle) |
| decReady | input | 1 | Decoder result ready |
| flagWord | input | 32 | Error flags and position count |
| posWords | input | 128 | Four packed words, two error positions each |
| bufRdData | input | 8 | Byte read from the sector buffer, one cycle after `bufRdEn` |
| bufRdEn | output | 1 | Sector buffer read strobe |
| bufWrEn | output | 1 | Sector buffer write strobe |
| bufAddr | output | 9 | Sector buffer byte address |
| bufWrData | output | 8 | Corrected byte to write |
| done | output | 1 | One-cycle completion pulse |
| isClean | output | 1 | Result: no errors reported |
| isCorrected | output | 1 | Result: positions applied |
| isUncorr | output | 1 | Result: uncorrectable sector |
| isTimeout | output | 1 | Result: decoder ready never arrived |

## Verification
For clean and uncorrectable sectors, `done` is due one edge after the edge that samples `decReady`. A corrected sector needs 2 + 3n + m edges from that edge. A missing ready ends exactly TIMEOUT_CYCLES edges after the start edge. The bench drives stimulus on falling edges and counts rising edges from the sampling edge up to the falling edge where `done` is first seen, then compares that count with the value the formula gives. On the following falling edge it confirms that `done` has dropped and the result flag is still held. A buffer model with one cycle of read latency records every access and the order of the writes. The bench compares those records, and the whole buffer, against flips it computes itself.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  typedef struct packed {
    logic latch;
    logic clrIdx;
    logic incIdx;
    logic rdEn;
    logic wrEn;
  } fixStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EVAL,
    ST_STEP,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } fixState_t;

endpackage

// File: rtl/bch_fix_dp.sv
module bch_fix_dp
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int POS_W        = 13,
  parameter int WORD_W       = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fixStrobe_t                   stb,
  input  logic [WORD_W-1:0]            flagWord,
  input  logic [(MAX_ERR/2)*WORD_W-1:0] posWords,
  input  logic [7:0]                   bufRdData,
  output logic                         errFound,
  output logic                         tooMany,
  output logic                         idxDone,
  output logic                         posInRange,
  output logic [$clog2(SECTOR_BYTES)-1:0] bufAddr,
  output logic [7:0]                   bufWrData
);

  localparam int PAIRS     = MAX_ERR / 2;
  localparam int ADDR_W    = $clog2(SECTOR_BYTES);
  localparam int CNT_W     = $clog2(MAX_ERR + 1);
  localparam int IDX_W     = $clog2(MAX_ERR);
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int HI_LSB    = WORD_W / 2;
  localparam int CNT_LSB   = 4;
  localparam int CNT_FW    = 4;

  logic [POS_W-1:0] posNext [MAX_ERR];
  logic [POS_W-1:0] posReg  [MAX_ERR];
  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] cntClamp;
  logic [CNT_FW-1:0] cntRaw;
  logic [POS_W-1:0] curPos;
  logic [7:0]       bitMask;
  logic             unusedFlagBits;

  // Unpack two positions from each status word.
  for (genvar k = 0; k < PAIRS; k++) begin : g_unpack
    logic [WORD_W-1:0] word;
    logic              unusedGap;
    assign word             = posWords[k*WORD_W +: WORD_W];
    assign posNext[2*k]     = word[POS_W-1:0];
    assign posNext[2*k + 1] = word[HI_LSB +: POS_W];
    assign unusedGap        = ^{word[HI_LSB-1:POS_W], word[WORD_W-1:HI_LSB+POS_W]};
  end

  assign unusedFlagBits = ^{flagWord[WORD_W-1:CNT_LSB+CNT_FW], flagWord[CNT_LSB-1:2]};

  assign cntRaw   = flagWord[CNT_LSB +: CNT_FW];
  assign cntClamp = (int'(cntRaw) > MAX_ERR) ? CNT_W'(MAX_ERR) : CNT_W'(cntRaw);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFound <= 1'b0;
      tooMany  <= 1'b0;
      countReg <= '0;
      for (int i = 0; i < MAX_ERR; i++) posReg[i] <= '0;
    end else if (stb.latch) begin
      errFound <= flagWord[1];
      tooMany  <= flagWord[0];
      countReg <= cntClamp;
      for (int i = 0; i < MAX_ERR; i++) posReg[i] <= posNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (stb.clrIdx) begin
      idx <= '0;
    end else if (stb.incIdx) begin
      idx <= idx + 1'b1;
    end
  end

  assign curPos     = posReg[idx[IDX_W-1:0]];
  assign idxDone    = (idx == countReg);
  assign posInRange = (int'(curPos) < DATA_BITS);
  assign bufAddr    = ADDR_W'(curPos >> 3);
  assign bitMask    = 8'b1 << curPos[2:0];
  assign bufWrData  = bufRdData ^ bitMask;

  // Read and write of one correction target the same byte.
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> $stable(bufAddr));

  // Never step past the clamped count.
  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.incIdx |-> (idx < countReg));

endmodule

// File: rtl/bch_fix_ctrl.sv
module bch_fix_ctrl
  import bch_fix_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       decReady,
  input  logic       errFound,
  input  logic       tooMany,
  input  logic       idxDone,
  input  logic       posInRange,
  output fixStrobe_t stb,
  output logic       done,
  output logic       isClean,
  output logic       isCorrected,
  output logic       isUncorr,
  output logic       isTimeout
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  fixState_t        state;
  logic [TMR_W-1:0] timer;

  always_comb begin
    stb = '0;
    unique case (state)
      ST_WAIT:  stb.latch  = decReady;
      ST_EVAL:  stb.clrIdx = 1'b1;
      ST_STEP:  stb.incIdx = !idxDone && !posInRange;
      ST_READ:  stb.rdEn   = 1'b1;
      ST_WRITE: begin
        stb.wrEn   = 1'b1;
        stb.incIdx = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      timer       <= '0;
      isClean     <= 1'b0;
      isCorrected <= 1'b0;
      isUncorr    <= 1'b0;
      isTimeout   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state       <= ST_WAIT;
          timer       <= '0;
          isClean     <= 1'b0;
          isCorrected <= 1'b0;
          isUncorr    <= 1'b0;
          isTimeout   <= 1'b0;
        end
        ST_WAIT: begin
          if (decReady) begin
            state <= ST_EVAL;
          end else if (timer == TMR_W'(TIMEOUT_CYCLES - 1)) begin
            state     <= ST_FIN;
            isTimeout <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_EVAL: begin
          if (!errFound) begin
            state   <= ST_FIN;
            isClean <= 1'b1;
          end else if (tooMany) begin
            state    <= ST_FIN;
            isUncorr <= 1'b1;
          end else begin
            state <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (idxDone) begin
            state       <= ST_FIN;
            isCorrected <= 1'b1;
          end else if (posInRange) begin
            state <= ST_READ;
          end
        end
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= ST_STEP;
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_FIN);

  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> stb.wrEn);

  assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> $past(stb.rdEn));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({isClean, isCorrected, isUncorr, isTimeout}) == 1));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isClean, isCorrected, isUncorr, isTimeout}));

  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (int'(timer) < TIMEOUT_CYCLES));

endmodule

// File: rtl/bch_fix_apply.sv
module bch_fix_apply
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES   = 512,
  parameter int MAX_ERR        = 8,
  parameter int POS_W          = 13,
  parameter int WORD_W         = 32,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          decReady,
  input  logic [WORD_W-1:0]             flagWord,
  input  logic [(MAX_ERR/2)*WORD_W-1:0] posWords,
  input  logic [7:0]                    bufRdData,
  output logic                          bufRdEn,
  output logic                          bufWrEn,
  output logic [$clog2(SECTOR_BYTES)-1:0] bufAddr,
  output logic [7:0]                    bufWrData,
  output logic                          done,
  output logic                          isClean,
  output logic                          isCorrected,
  output logic                          isUncorr,
  output logic                          isTimeout
);

  fixStrobe_t stb;
  logic       errFound;
  logic       tooMany;
  logic       idxDone;
  logic       posInRange;

  bch_fix_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .decReady   (decReady),
    .errFound   (errFound),
    .tooMany    (tooMany),
    .idxDone    (idxDone),
    .posInRange (posInRange),
    .stb        (stb),
    .done       (done),
    .isClean    (isClean),
    .isCorrected(isCorrected),
    .isUncorr   (isUncorr),
    .isTimeout  (isTimeout)
  );

  bch_fix_dp #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .MAX_ERR     (MAX_ERR),
    .POS_W       (POS_W),
    .WORD_W      (WORD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .flagWord  (flagWord),
    .posWords  (posWords),
    .bufRdData (bufRdData),
    .errFound  (errFound),
    .tooMany   (tooMany),
    .idxDone   (idxDone),
    .posInRange(posInRange),
    .bufAddr   (bufAddr),
    .bufWrData (bufWrData)
  );

  assign bufRdEn = stb.rdEn;
  assign bufWrEn = stb.wrEn;

endmodule

// File: tb/bch_fix_apply_tb.sv
module bch_fix_apply_tb;

  localparam int TMO = 256;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         decReady = 1'b0;
  logic [31:0]  flagWord = '0;
  logic [127:0] posWords = '0;
  logic [7:0]   bufRdData;
  logic         bufRdEn, bufWrEn;
  logic [8:0]   bufAddr;
  logic [7:0]   bufWrData;
  logic         done, isClean, isCorrected, isUncorr, isTimeout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem  [512];
  logic [7:0] emem [512];
  logic [8:0] wrLog [128];
  int rdCnt = 0;
  int wrCnt = 0;

  always #4 clk = ~clk;

  bch_fix_apply #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .decReady(decReady),
    .flagWord(flagWord), .posWords(posWords), .bufRdData(bufRdData),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufAddr(bufAddr),
    .bufWrData(bufWrData), .done(done), .isClean(isClean),
    .isCorrected(isCorrected), .isUncorr(isUncorr), .isTimeout(isTimeout)
  );

  // Sector buffer model with one cycle of read latency.
  always @(posedge clk) begin
    if (bufRdEn) begin
      bufRdData <= mem[bufAddr];
      rdCnt <= rdCnt + 1;
    end
    if (bufWrEn) begin
      mem[bufAddr] <= bufWrData;
      if (wrCnt < 128) wrLog[wrCnt] <= bufAddr;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkFlags(input bit unc, input bit found, input int cnt);
    logic [31:0] f;
    f = '0;
    f[0] = unc;
    f[1] = found;
    f[7:4] = 4'(cnt);
    return f;
  endfunction

  function automatic logic [127:0] packPos(input logic [12:0] p [8]);
    logic [127:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      w[k*32 +: 13]      = p[2*k];
      w[k*32 + 16 +: 13] = p[2*k + 1];
    end
    return w;
  endfunction

  function automatic int expCount(input int cnt);
    return (cnt > 8) ? 8 : cnt;
  endfunction

  task automatic applyExp(input logic [12:0] p [8], input int cnt);
    for (int i = 0; i < expCount(cnt); i++)
      if (p[i] < 13'd4096) emem[p[i] >> 3] ^= 8'(1 << p[i][2:0]);
  endtask

  // Runs one sector. res = {clean, corrected, uncorr, timeout}.
  task automatic runSector(input logic [31:0] f, input logic [127:0] pw,
                           input bit withReady, input int readyDelay,
                           output int lat, output logic [3:0] res,
                           output int rdUsed, output int wrUsed);
    int rd0, wr0;
    logic [3:0] held;
    rd0 = rdCnt;
    wr0 = wrCnt;
    @(negedge clk);
    flagWord = f;
    posWords = pw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (withReady) begin
      repeat (readyDelay) @(negedge clk);
      chk(!done && rdCnt == rd0 && wrCnt == wr0, "R2 idle before ready",
          rdCnt - rd0 + wrCnt - wr0 + int'(done), 0);
      decReady = 1'b1;
      @(negedge clk);
      decReady = 1'b0;
      flagWord = 32'h0000_00F1;
      posWords = '1;
    end
    lat = 0;
    while (!done && lat < 600) begin
      @(negedge clk);
      lat++;
    end
    res = {isClean, isCorrected, isUncorr, isTimeout};
    rdUsed = rdCnt - rd0;
    wrUsed = wrCnt - wr0;
    @(negedge clk);
    held = {isClean, isCorrected, isUncorr, isTimeout};
    chk(!done, "R10 done one cycle", int'(done), 0);
    chk(held == res, "R10 result held", int'(held), int'(res));
  endtask

  task automatic chkMem(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== emem[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic testReset();
    chk(!done && !bufRdEn && !bufWrEn, "R1 strobes low", int'({done, bufRdEn, bufWrEn}), 0);
    chk({isClean, isCorrected, isUncorr, isTimeout} == 4'b0, "R1 results low",
        int'({isClean, isCorrected, isUncorr, isTimeout}), 0);
  endtask

  task automatic testClean();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'(i * 9);
    runSector(mkFlags(1'b1, 1'b0, 3), packPos(p), 1'b1, 5, lat, res, rd, wr);
    chk(res == 4'b1000, "R4 clean result", int'(res), 8);
    chk(lat == 1, "R4 clean latency", lat, 1);
    chk(rd + wr == 0, "R4 no access", rd + wr, 0);
    chkMem("R4 buffer untouched");
  endtask

  task automatic testUncorr();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'(i * 17 + 3);
    runSector(mkFlags(1'b1, 1'b1, 2), packPos(p), 1'b1, 0, lat, res, rd, wr);
    chk(res == 4'b0010, "R5 uncorr result", int'(res), 2);
    chk(lat == 1, "R5 uncorr latency", lat, 1);
    chk(rd + wr == 0, "R5 no access", rd + wr, 0);
    chkMem("R5 buffer untouched");
  endtask

  task automatic testTimeout();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'(i);
    runSector(mkFlags(1'b0, 1'b1, 8), packPos(p), 1'b0, 0, lat, res, rd, wr);
    chk(res == 4'b0001, "R3 timeout result", int'(res), 1);
    chk(lat == TMO, "R3 timeout latency", lat, TMO);
    chk(rd + wr == 0, "R3 no access", rd + wr, 0);
  endtask

  task automatic testSingle();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'd5000;
    p[0] = 13'd100;
    applyExp(p, 1);
    runSector(mkFlags(1'b0, 1'b1, 1), packPos(p), 1'b1, 2, lat, res, rd, wr);
    chk(res == 4'b0100, "R8 corrected result", int'(res), 4);
    chk(lat == 5, "R12 single latency", lat, 5);
    chk(rd == 1 && wr == 1, "R8 one read one write", rd * 10 + wr, 11);
    chkMem("R8 bit 4 of byte 12 flipped");
  endtask

  task automatic testOrder();
    logic [12:0] p [8];
    int lat, rd, wr, wr0;
    logic [3:0] res;
    int expA [8];
    p = '{13'd4000, 13'd7, 13'd2049, 13'd800, 13'd15, 13'd3333, 13'd1030, 13'd600};
    for (int i = 0; i < 8; i++) expA[i] = int'(p[i]) / 8;
    applyExp(p, 8);
    wr0 = wrCnt;
    runSector(mkFlags(1'b0, 1'b1, 8), packPos(p), 1'b1, 1, lat, res, rd, wr);
    chk(res == 4'b0100, "R7 corrected result", int'(res), 4);
    chk(lat == 26, "R12 eight-position latency", lat, 26);
    for (int i = 0; i < 8; i++)
      chk(int'(wrLog[wr0 + i]) == expA[i], "R7 write order", int'(wrLog[wr0 + i]), expA[i]);
    chkMem("R7 all eight flips");
  endtask

  task automatic testSkip();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    p = '{13'd4095, 13'd4096, 13'd8191, 13'd0, 13'd50, 13'd51, 13'd52, 13'd53};
    applyExp(p, 4);
    runSector(mkFlags(1'b0, 1'b1, 4), packPos(p), 1'b1, 0, lat, res, rd, wr);
    chk(res == 4'b0100, "R9 corrected result", int'(res), 4);
    chk(lat == 10, "R9 skip latency", lat, 10);
    chk(wr == 2, "R9 parity positions skipped", wr, 2);
    chkMem("R9 only data bits flipped");
  endtask

  task automatic testClamp();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'(i * 64 + 1);
    applyExp(p, 15);
    runSector(mkFlags(1'b0, 1'b1, 15), packPos(p), 1'b1, 0, lat, res, rd, wr);
    chk(wr == 8, "R6 count clamped to 8", wr, 8);
    chk(lat == 26, "R6 clamped latency", lat, 26);
    chkMem("R6 clamped flips");
    runSector(mkFlags(1'b0, 1'b1, 0), packPos(p), 1'b1, 0, lat, res, rd, wr);
    chk(res == 4'b0100, "R6 zero count corrected", int'(res), 4);
    chk(rd + wr == 0 && lat == 2, "R6 zero count no access", rd + wr + lat, 2);
  endtask

  task automatic testSameByte();
    logic [12:0] p [8];
    int lat, rd, wr;
    logic [3:0] res;
    for (int i = 0; i < 8; i++) p[i] = 13'd0;
    p[0] = 13'd80;
    p[1] = 13'd83;
    applyExp(p, 2);
    runSector(mkFlags(1'b0, 1'b1, 2), packPos(p), 1'b1, 3, lat, res, rd, wr);
    chk(lat == 8, "R11 same-byte latency", lat, 8);
    chk(mem[10] === emem[10], "R11 both bits of byte 10", int'(mem[10]), int'(emem[10]));
    chkMem("R11 buffer");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]  = 8'(i * 37 + 5);
      emem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testUncorr();
    testTimeout();
    testSingle();
    testOrder();
    testSkip();
    testClamp();
    testSameByte();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule